// File: doc/BRIEF.md
# Latched Interrupt Status Hub

This block is the top-level interrupt status register of a multi-channel power controller. Five event inputs (external clock lost, thermal shutdown, thermal warning, input overvoltage, load measurement ready) are captured in sticky flags. Software clears a flag by writing 1 to its position. Two more bits summarise two 8-bit per-channel-pair sub-registers, which are also held in this block. These sub-registers use the same write-one-to-clear scheme and have their own event vectors.

Software reaches the block through a synchronous port: a write strobe, an address, write data, and combinational read data. The block also drives three other outputs. The first is a single interrupt request. The second is a regulator enable vector, which is inhibited while the thermal shutdown flag is latched. The third is a registered copy of the live thermal and overvoltage levels, and clearing a latch never changes this copy.

Top module: `irq_status_hub`

## Requirements
- R1: After reset, every address reads 0x00, `irq` is 0 and `live_stat` is 0.
- R2: At address 0, bit 4 latches clock loss, bit 3 thermal shutdown, bit 2 thermal warning, bit 1 overvoltage and bit 0 measurement ready. Each flag stays set until a write to address 0 has a 1 in that bit position. Writing 0 leaves the flag unchanged.
- R3: When an event is high in the same cycle as a write-one-clear of its flag, the flag stays 1. An event level that is still high keeps the flag set after the clear.
- R4: Bit 5 of address 0 reads 1 exactly while the sub-register at address 1 is non-zero. Bit 6 reads 1 exactly while the sub-register at address 2 is non-zero. Writes to bits 6 and 5 have no effect.
- R5: Addresses 1 and 2 are 8-bit sub-registers. Bit i is set by bit i of `pair01_evt` or `pair23_evt` respectively, and is cleared by writing 1 to bit i. Set wins over clear in the same cycle.
- R6: Bit 7 of address 0 is a plain read/write storage bit. It does not take part in `irq`.
- R7: `en_out` equals `en_req` while the thermal shutdown flag is clear. It is all zeros while that flag is set.
- R8: `live_stat` = {tsd, warn, ovp} levels delayed by one clock. Address 3 reads the same value in bits 2:0 with zeros above. Clearing a latched flag does not change it.
- R9: `irq` is 1 while any of bits 6..0 of address 0 is 1. It drops in the cycle right after the write that clears the last pending source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| addr | input | ADDR_W | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |
| evt_clk_loss | input | 1 | External clock invalid event |
| evt_tsd | input | 1 | Thermal shutdown event |
| evt_twarn | input | 1 | Thermal warning event |
| evt_ovp | input | 1 | Input overvoltage event |
| evt_meas_rdy | input | 1 | Load measurement ready event |
| lvl_tsd | input | 1 | Live thermal shutdown level |
| lvl_twarn | input | 1 | Live thermal warning level |
| lvl_ovp | input | 1 | Live overvoltage level |
| pair01_evt | input | SUB_W | Event vector for channels 0/1 |
| pair23_evt | input | SUB_W | Event vector for channels 2/3 |
| en_req | input | NUM_REG | Requested regulator enables |
| en_out | output | NUM_REG | Granted regulator enables |
| live_stat | output | 3 | Registered live levels {tsd, warn, ovp} |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its defaults: a 2-bit address, 8-bit sub-registers and four regulator enables. These values put every address within reach of a read, including the live-level view at address 3. They also let each enable bit be watched while a thermal shutdown latch comes and goes. Full 8-bit sub-registers allow partial clears, which show that a summary bit holds until the last bit of its sub-register is gone.

// File: rtl/irq_status_hub.sv
module irq_status_hub #(
  parameter int ADDR_W  = 2,
  parameter int SUB_W   = 8,
  parameter int NUM_REG = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [7:0]         wdata,
  output logic [7:0]         rdata,
  input  logic               evt_clk_loss,
  input  logic               evt_tsd,
  input  logic               evt_twarn,
  input  logic               evt_ovp,
  input  logic               evt_meas_rdy,
  input  logic               lvl_tsd,
  input  logic               lvl_twarn,
  input  logic               lvl_ovp,
  input  logic [SUB_W-1:0]   pair01_evt,
  input  logic [SUB_W-1:0]   pair23_evt,
  input  logic [NUM_REG-1:0] en_req,
  output logic [NUM_REG-1:0] en_out,
  output logic [2:0]         live_stat,
  output logic               irq
);
  localparam logic [ADDR_W-1:0] ADR_TOP  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] ADR_P01  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] ADR_P23  = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] ADR_LIVE = ADDR_W'(3);
  localparam int TSD_BIT = 3;

  logic [4:0]       lat_q;
  logic             spare_q;
  logic [SUB_W-1:0] p01_q, p23_q;
  logic [2:0]       live_q;

  logic             wr_top, wr_p01, wr_p23;
  logic [4:0]       evt_vec;
  logic             sum01, sum23;

  assign wr_top  = wr_en && (addr == ADR_TOP);
  assign wr_p01  = wr_en && (addr == ADR_P01);
  assign wr_p23  = wr_en && (addr == ADR_P23);
  assign evt_vec = {evt_clk_loss, evt_tsd, evt_twarn, evt_ovp, evt_meas_rdy};
  assign sum01   = |p01_q;
  assign sum23   = |p23_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q   <= '0;
      spare_q <= 1'b0;
      p01_q   <= '0;
      p23_q   <= '0;
      live_q  <= '0;
    end else begin
      lat_q  <= (lat_q & ~(wr_top ? wdata[4:0] : 5'd0)) | evt_vec;
      p01_q  <= (p01_q & ~(wr_p01 ? wdata[SUB_W-1:0] : '0)) | pair01_evt;
      p23_q  <= (p23_q & ~(wr_p23 ? wdata[SUB_W-1:0] : '0)) | pair23_evt;
      live_q <= {lvl_tsd, lvl_twarn, lvl_ovp};
      if (wr_top) spare_q <= wdata[7];
    end
  end

  always_comb begin
    case (addr)
      ADR_TOP:  rdata = {spare_q, sum23, sum01, lat_q};
      ADR_P01:  rdata = 8'(p01_q);
      ADR_P23:  rdata = 8'(p23_q);
      ADR_LIVE: rdata = {5'd0, live_q};
      default:  rdata = 8'd0;
    endcase
  end

  assign en_out    = lat_q[TSD_BIT] ? '0 : en_req;
  assign live_stat = live_q;
  assign irq       = (|lat_q) | sum01 | sum23;

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    evt_tsd |=> lat_q[TSD_BIT]); // R3
  AST_W0_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (lat_q[1] && !(wr_top && wdata[1])) |=> lat_q[1]); // R2
  AST_TSD_INHIBIT: assert property (@(posedge clk) disable iff (!rst_n)
    lat_q[TSD_BIT] |-> (en_out == '0)); // R7
  AST_SUM01_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sum01) |-> $past(wr_p01)); // R4
  AST_P23_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sum23) |-> $past(wr_en && addr == ADR_P23)); // R5
  AST_IRQ_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(wr_en)); // R9
  AST_LIVE_ROSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(live_stat[2]) |-> $past(lvl_tsd)); // R8
endmodule

// File: tb/irq_status_hub_bench.sv
module irq_status_hub_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic       evt_clk_loss = 0, evt_tsd = 0, evt_twarn = 0, evt_ovp = 0, evt_meas_rdy = 0;
  logic       lvl_tsd = 0, lvl_twarn = 0, lvl_ovp = 0;
  logic [7:0] pair01_evt = 8'd0, pair23_evt = 8'd0;
  logic [3:0] en_req = 4'd0;
  logic [3:0] en_out;
  logic [2:0] live_stat;
  logic       irq;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  irq_status_hub u_irq_status_hub (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .evt_clk_loss(evt_clk_loss), .evt_tsd(evt_tsd), .evt_twarn(evt_twarn),
    .evt_ovp(evt_ovp), .evt_meas_rdy(evt_meas_rdy),
    .lvl_tsd(lvl_tsd), .lvl_twarn(lvl_twarn), .lvl_ovp(lvl_ovp),
    .pair01_evt(pair01_evt), .pair23_evt(pair23_evt),
    .en_req(en_req), .en_out(en_out), .live_stat(live_stat), .irq(irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; wdata = 8'd0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), d);
      chk("R1 read after reset", d, 8'h00);
    end
    chk("R1 irq after reset", {7'd0, irq}, 8'h00);
    chk("R1 live after reset", {5'd0, live_stat}, 8'h00);
  endtask

  task automatic t_top_latch();
    logic [7:0] d;
    evt_clk_loss = 1; evt_tsd = 1; evt_twarn = 1; evt_ovp = 1; evt_meas_rdy = 1;
    @(negedge clk);
    evt_clk_loss = 0; evt_tsd = 0; evt_twarn = 0; evt_ovp = 0; evt_meas_rdy = 0;
    rd(2'd0, d); chk("R2 all flags latched", d, 8'h1F);
    wr(2'd0, 8'h00);
    rd(2'd0, d); chk("R2 write 0 keeps flags", d, 8'h1F);
    wr(2'd0, 8'h04);
    rd(2'd0, d); chk("R2 clear warn only", d, 8'h1B);
    wr(2'd0, 8'h1B);
    rd(2'd0, d); chk("R2 clear rest", d, 8'h00);
  endtask

  task automatic t_priority();
    logic [7:0] d;
    evt_ovp = 1;
    wr(2'd0, 8'h02);
    rd(2'd0, d); chk("R3 set wins same cycle", d, 8'h02);
    wr(2'd0, 8'h02);
    evt_ovp = 0;
    rd(2'd0, d); chk("R3 held level re-sets", d, 8'h02);
    wr(2'd0, 8'h02);
    rd(2'd0, d); chk("R3 clear after level drops", d, 8'h00);
  endtask

  task automatic t_summary();
    logic [7:0] d;
    pair01_evt = 8'h81;
    @(negedge clk);
    pair01_evt = 8'h00;
    rd(2'd0, d); chk("R4 summary01 set", d, 8'h20);
    wr(2'd0, 8'h60);
    rd(2'd0, d); chk("R4 summary write ignored", d, 8'h20);
    wr(2'd1, 8'h01);
    rd(2'd1, d); chk("R5 partial clear p01", d, 8'h80);
    rd(2'd0, d); chk("R4 summary01 holds", d, 8'h20);
    pair01_evt = 8'h80;
    wr(2'd1, 8'h80);
    pair01_evt = 8'h00;
    rd(2'd1, d); chk("R5 set wins p01", d, 8'h80);
    wr(2'd1, 8'h80);
    rd(2'd0, d); chk("R4 summary01 clears", d, 8'h00);
    pair23_evt = 8'h10;
    @(negedge clk);
    pair23_evt = 8'h00;
    rd(2'd0, d); chk("R4 summary23 set", d, 8'h40);
    rd(2'd2, d); chk("R5 p23 content", d, 8'h10);
    wr(2'd2, 8'hEF);
    rd(2'd2, d); chk("R5 p23 write 0 keeps", d, 8'h10);
    wr(2'd2, 8'h10);
    rd(2'd0, d); chk("R4 summary23 clears", d, 8'h00);
  endtask

  task automatic t_spare();
    logic [7:0] d;
    wr(2'd0, 8'h80);
    rd(2'd0, d); chk("R6 spare bit written", d, 8'h80);
    chk("R6 spare not in irq", {7'd0, irq}, 8'h00);
    wr(2'd0, 8'h00);
    rd(2'd0, d); chk("R6 spare bit cleared", d, 8'h00);
  endtask

  task automatic t_tsd();
    en_req = 4'hA;
    @(negedge clk);
    chk("R7 enables pass", {4'd0, en_out}, 8'h0A);
    evt_tsd = 1;
    @(negedge clk);
    evt_tsd = 0;
    chk("R7 enables inhibited", {4'd0, en_out}, 8'h00);
    en_req = 4'hF;
    #1;
    chk("R7 new request refused", {4'd0, en_out}, 8'h00);
    wr(2'd0, 8'h08);
    chk("R7 enables back", {4'd0, en_out}, 8'h0F);
    en_req = 4'h0;
  endtask

  task automatic t_live();
    logic [7:0] d;
    lvl_tsd = 1; lvl_ovp = 1;
    #1;
    chk("R8 not before edge", {5'd0, live_stat}, 8'h00);
    @(negedge clk);
    chk("R8 live after edge", {5'd0, live_stat}, 8'h05);
    rd(2'd3, d); chk("R8 live via address 3", d, 8'h05);
    evt_twarn = 1;
    @(negedge clk);
    evt_twarn = 0;
    wr(2'd0, 8'h04);
    chk("R8 clear leaves live", {5'd0, live_stat}, 8'h05);
    lvl_tsd = 0; lvl_ovp = 0;
    @(negedge clk);
    chk("R8 live follows drop", {5'd0, live_stat}, 8'h00);
  endtask

  task automatic t_irq();
    evt_meas_rdy = 1;
    @(negedge clk);
    evt_meas_rdy = 0;
    pair23_evt = 8'h02;
    @(negedge clk);
    pair23_evt = 8'h00;
    chk("R9 irq set", {7'd0, irq}, 8'h01);
    wr(2'd0, 8'h01);
    chk("R9 irq held by summary", {7'd0, irq}, 8'h01);
    addr = 2'd2; wdata = 8'h02; wr_en = 1'b1;
    #1;
    chk("R9 irq high during clear write", {7'd0, irq}, 8'h01);
    @(posedge clk);
    #1;
    wr_en = 1'b0;
    chk("R9 irq low right after clear", {7'd0, irq}, 8'h00);
    @(negedge clk);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_top_latch();
    t_priority();
    t_summary();
    t_spare();
    t_tsd();
    t_live();
    t_irq();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule